// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block watches the receive byte stream of an Ethernet port and decides, once per frame, whether the frame should be kept or dropped, based only on its 48-bit destination address. Bytes arrive one per cycle with a valid strobe, a start-of-frame flag and an end-of-frame flag. The first six bytes of a frame form the destination address, most significant octet first. Once the sixth byte has been taken, a registered decision pulse reports accept or discard. Bytes after the address are passed over until the frame ends.

Three rules decide the outcome. The all-ones broadcast address is always kept. A frame whose group bit is set is a multicast frame. When multicast filtering is on, such a frame is kept only if every bit that is 1 in a 32-bit mask is also 1 in the low 32 bits of the address. When filtering is off, every multicast frame is kept. Any other frame is an individual frame and is kept only if its address equals the programmed local station address exactly.

The local address, the mask and the enable are held in small registers inside the block. A separate write strobe loads each of them from one shared write-data bus. Payload storage and CRC checking are handled by other blocks.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset the local address is all zeros, the mask is all zeros and multicast filtering is off. dec_valid stays low during reset. A frame addressed to 00:00:00:00:00:00 is accepted before any configuration write.
- R2: Address bytes are taken most significant octet first. cfg_wr_hi loads address bits 47:32 from cfg_wdata[15:0], and cfg_wr_lo loads bits 31:0 from cfg_wdata[31:0]. A frame with the group bit clear is accepted only when all 48 bits equal the programmed local address.
- R3: The group bit is bit 0 of the first address octet (address bit 40). The address FF:FF:FF:FF:FF:FF is always accepted.
- R4: cfg_wr_ctrl loads the multicast filter enable from cfg_wdata[0], and cfg_wr_mask loads the mask from cfg_wdata[31:0]. With the group bit set and filtering on, a non-broadcast frame is accepted only if (address[31:0] & mask) == mask.
- R5: With the group bit set and filtering off, the frame is accepted whatever the mask holds.
- R6: Each frame produces exactly one decision pulse. For a complete address, dec_valid is high for one cycle, in the cycle after the edge that takes the sixth address byte.
- R7: A frame whose end-of-frame flag arrives on one of its first five bytes produces one discard pulse (dec_valid=1, dec_accept=0), in the cycle after the edge that takes that byte.
- R8: Cycles with in_valid low are ignored and produce no decision in the following cycle. in_sof on a byte inside a frame is treated as ordinary data. Bytes after the sixth produce no further decision.
- R9: While no frame is open, bytes without in_sof are ignored and produce no decision.
- R10: With filtering on and the mask all zeros, every multicast frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_hi | input | 1 | Load upper 16 local address bits |
| cfg_wr_lo | input | 1 | Load lower 32 local address bits |
| cfg_wr_mask | input | 1 | Load multicast mask |
| cfg_wr_ctrl | input | 1 | Load multicast filter enable (bit 0) |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Receive byte valid |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_byte | input | 8 | Receive byte |
| dec_valid | output | 1 | Decision pulse, one per frame |
| dec_accept | output | 1 | 1 = keep frame, 0 = discard (valid with dec_valid) |

## Verification
The awkward cases are those where the framing flags and the address disagree. A start flag can land on a byte inside the address, idle cycles can sit between address bytes, and a frame can end on its first, third or fifth byte. In each case the bench still predicts exactly one pulse, at a cycle it computes from the position of the last address byte. The subset rule is driven with addresses that miss the mask by a single bit in different octets. The same addresses are then replayed after the mask is cleared or filtering is switched off, so that only the configuration changes the outcome.

// File: rtl/dfl_pkg.sv
package dfl_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_ADDR = 2'd1,
        CAP_TAIL = 2'd2
    } cap_state_e;

endpackage

// File: rtl/dfl_cfg_regs.sv
module dfl_cfg_regs #(
    parameter int DATA_W = 32,
    parameter int HI_W   = 16,
    parameter int MASK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic              wr_mask,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic [HI_W-1:0]   loc_hi,
    output logic [DATA_W-1:0] loc_lo,
    output logic [MASK_W-1:0] mask,
    output logic              mc_en
);

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [DATA_W-1:0] lo;
        logic [MASK_W-1:0] mask;
        logic              en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_hi)   cfg_d.hi   = wdata[HI_W-1:0];
        if (wr_lo)   cfg_d.lo   = wdata;
        if (wr_mask) cfg_d.mask = wdata[MASK_W-1:0];
        if (wr_ctrl) cfg_d.en   = wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign loc_hi = cfg_q.hi;
    assign loc_lo = cfg_q.lo;
    assign mask   = cfg_q.mask;
    assign mc_en  = cfg_q.en;

endmodule

// File: rtl/dfl_addr_capture.sv
module dfl_addr_capture
    import dfl_pkg::*;
#(
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sof,
    input  logic                    in_eof,
    input  logic [7:0]              in_byte,
    output logic                    addr_done,
    output logic                    addr_trunc,
    output logic [ADDR_BYTES*8-1:0] addr_word
);

    localparam int SH_W  = (ADDR_BYTES - 1) * 8;
    localparam int CNT_W = $clog2(ADDR_BYTES);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

    typedef struct packed {
        cap_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [SH_W-1:0]  sh;
    } cap_t;

    cap_t cap_d, cap_q;
    logic done_c, trunc_c;

    always_comb begin
        cap_d   = cap_q;
        done_c  = 1'b0;
        trunc_c = 1'b0;
        case (cap_q.st)
            CAP_IDLE: begin
                if (in_valid && in_sof) begin
                    cap_d.sh  = {cap_q.sh[SH_W-9:0], in_byte};
                    cap_d.cnt = CNT_W'(1);
                    if (in_eof) trunc_c  = 1'b1;
                    else        cap_d.st = CAP_ADDR;
                end
            end
            CAP_ADDR: begin
                if (in_valid) begin
                    if (cap_q.cnt == LAST_IDX) begin
                        done_c   = 1'b1;
                        cap_d.st = in_eof ? CAP_IDLE : CAP_TAIL;
                    end else begin
                        cap_d.sh  = {cap_q.sh[SH_W-9:0], in_byte};
                        cap_d.cnt = cap_q.cnt + CNT_W'(1);
                        if (in_eof) begin
                            trunc_c  = 1'b1;
                            cap_d.st = CAP_IDLE;
                        end
                    end
                end
            end
            CAP_TAIL: begin
                if (in_valid && in_eof) cap_d.st = CAP_IDLE;
            end
            default: cap_d.st = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '{st: CAP_IDLE, cnt: '0, sh: '0};
        else        cap_q <= cap_d;
    end

    assign addr_done  = done_c;
    assign addr_trunc = trunc_c;
    assign addr_word  = {cap_q.sh, in_byte};

endmodule

// File: rtl/dfl_decide.sv
module dfl_decide #(
    parameter int ADDR_W = 48,
    parameter int MASK_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] local_addr,
    input  logic [MASK_W-1:0] mask,
    input  logic              mc_en,
    output logic              accept
);

    localparam int GROUP_BIT = ADDR_W - 8;

    logic is_bcast, is_group, subset_ok, uc_match;

    always_comb begin
        is_bcast  = &addr;
        is_group  = addr[GROUP_BIT];
        subset_ok = ((addr[MASK_W-1:0] & mask) == mask);
        uc_match  = (addr == local_addr);
        if (is_bcast)      accept = 1'b1;
        else if (is_group) accept = mc_en ? subset_ok : 1'b1;
        else               accept = uc_match;
    end

endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter #(
    parameter int ADDR_BYTES = 6,
    parameter int DATA_W     = 32,
    parameter int MASK_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_hi,
    input  logic              cfg_wr_lo,
    input  logic              cfg_wr_mask,
    input  logic              cfg_wr_ctrl,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [7:0]        in_byte,
    output logic              dec_valid,
    output logic              dec_accept
);

    localparam int ADDR_W = ADDR_BYTES * 8;
    localparam int HI_W   = ADDR_W - DATA_W;

    logic [HI_W-1:0]   loc_hi;
    logic [DATA_W-1:0] loc_lo;
    logic [ADDR_W-1:0] local_addr;
    logic [MASK_W-1:0] mcast_mask;
    logic              mcast_en;
    logic              addr_done, addr_trunc, acc_c;
    logic [ADDR_W-1:0] addr_word;

    dfl_cfg_regs #(.DATA_W(DATA_W), .HI_W(HI_W), .MASK_W(MASK_W)) cfg_i (
        .clk(clk), .rst_n(rst_n),
        .wr_hi(cfg_wr_hi), .wr_lo(cfg_wr_lo),
        .wr_mask(cfg_wr_mask), .wr_ctrl(cfg_wr_ctrl),
        .wdata(cfg_wdata),
        .loc_hi(loc_hi), .loc_lo(loc_lo),
        .mask(mcast_mask), .mc_en(mcast_en)
    );

    assign local_addr = {loc_hi, loc_lo};

    dfl_addr_capture #(.ADDR_BYTES(ADDR_BYTES)) cap_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_byte(in_byte),
        .addr_done(addr_done), .addr_trunc(addr_trunc),
        .addr_word(addr_word)
    );

    dfl_decide #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) dec_i (
        .addr(addr_word), .local_addr(local_addr),
        .mask(mcast_mask), .mc_en(mcast_en),
        .accept(acc_c)
    );

    typedef struct packed {
        logic valid;
        logic accept;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        dec_d.valid  = addr_done | addr_trunc;
        dec_d.accept = addr_done & acc_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign dec_valid  = dec_q.valid;
    assign dec_accept = dec_q.accept;

endmodule

// File: rtl/dfl_filter_chk.sv
module dfl_filter_chk #(
    parameter int ADDR_W = 48,
    parameter int MASK_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              dec_valid,
    input logic              dec_accept,
    input logic              addr_done,
    input logic              addr_trunc,
    input logic [ADDR_W-1:0] addr_word,
    input logic [ADDR_W-1:0] local_addr,
    input logic [MASK_W-1:0] mask,
    input logic              mcast_en
);

    localparam int GB = ADDR_W - 8;

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |=> !dec_valid);

    a_r2_unicast_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_done && !addr_word[GB]) |=>
            (dec_valid && (dec_accept == ($past(addr_word) == $past(local_addr)))));

    a_r3_broadcast_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_done && (&addr_word)) |=> (dec_valid && dec_accept));

    a_r4_subset_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_done && addr_word[GB] && mcast_en && !(&addr_word)) |=>
            (dec_accept == (($past(addr_word[MASK_W-1:0]) & $past(mask)) == $past(mask))));

    a_r5_filter_off_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_done && addr_word[GB] && !mcast_en) |=> dec_accept);

    a_r6_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_done && addr_trunc));

    a_r7_short_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        addr_trunc |=> (dec_valid && !dec_accept));

    a_r8_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !dec_valid);

endmodule

bind dst_addr_filter dfl_filter_chk #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .dec_valid(dec_valid), .dec_accept(dec_accept),
    .addr_done(addr_done), .addr_trunc(addr_trunc),
    .addr_word(addr_word), .local_addr(local_addr),
    .mask(mcast_mask), .mcast_en(mcast_en)
);

// File: tb/dst_addr_filter_tb_top.sv
module dst_addr_filter_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr_hi = 0, cfg_wr_lo = 0, cfg_wr_mask = 0, cfg_wr_ctrl = 0;
    logic [31:0] cfg_wdata = '0;
    logic in_valid = 0, in_sof = 0, in_eof = 0;
    logic [7:0] in_byte = '0;
    logic dec_valid, dec_accept;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int npulse = 0;
    int last_cyc = -1;
    logic last_acc = 1'b0;
    logic finished = 1'b0;

    always #5 clk = ~clk;

    dst_addr_filter dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_hi(cfg_wr_hi), .cfg_wr_lo(cfg_wr_lo),
        .cfg_wr_mask(cfg_wr_mask), .cfg_wr_ctrl(cfg_wr_ctrl),
        .cfg_wdata(cfg_wdata),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_byte(in_byte),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && dec_valid) begin
            npulse   <= npulse + 1;
            last_cyc <= cyc;
            last_acc <= dec_accept;
        end
    end

    typedef struct packed {
        logic [47:0] da;
        logic [3:0]  pay;
        logic        exp;
    } vec_t;

    // local 02:11:22:33:44:55, mask 00F00001, filtering on
    localparam vec_t VECS [0:8] = '{
        '{48'h02_11_22_33_44_55, 4'd0, 1'b1},
        '{48'h02_11_22_33_44_54, 4'd3, 1'b0},
        '{48'h03_11_22_33_44_55, 4'd2, 1'b0},
        '{48'h01_00_5E_F0_00_01, 4'd4, 1'b1},
        '{48'h01_00_5E_70_00_01, 4'd1, 1'b0},
        '{48'hFF_FF_FF_FF_FF_FF, 4'd0, 1'b1},
        '{48'hFF_FF_FF_FF_FF_FE, 4'd2, 1'b0},
        '{48'h12_11_22_33_44_55, 4'd1, 1'b0},
        '{48'h02_11_22_33_44_55, 4'd9, 1'b1}
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int sel, input logic [31:0] d);
        cfg_wdata   = d;
        cfg_wr_hi   = (sel == 0);
        cfg_wr_lo   = (sel == 1);
        cfg_wr_mask = (sel == 2);
        cfg_wr_ctrl = (sel == 3);
        @(negedge clk);
        cfg_wr_hi = 0; cfg_wr_lo = 0; cfg_wr_mask = 0; cfg_wr_ctrl = 0;
    endtask

    task automatic send_frame(input logic [47:0] da, input int nab, input int pay,
                              input int sof_at, input int gap_at, input logic exp,
                              input string tag);
        int total, last_ab, base_p, e_cyc;
        total   = (nab < 6) ? nab : 6 + pay;
        last_ab = (nab < 6) ? nab - 1 : 5;
        base_p  = npulse;
        e_cyc   = -1;
        for (int i = 0; i < total; i++) begin
            if (i == gap_at) begin
                in_valid = 0;
                in_byte  = 8'h5A;
                in_eof   = 1;
                @(negedge clk);
                @(negedge clk);
            end
            in_valid = 1;
            in_sof   = (i == 0) || (i == sof_at);
            in_eof   = (i == total - 1);
            in_byte  = (i < 6) ? da[47-8*i -: 8] : 8'(8'hA0 + i);
            @(negedge clk);
            if (i == last_ab) e_cyc = cyc;
        end
        in_valid = 0; in_sof = 0; in_eof = 0; in_byte = '0;
        repeat (3) @(negedge clk);
        check(npulse == base_p + 1, {tag, " pulse count"}, npulse - base_p, 1);
        check(last_cyc == e_cyc, {tag, " pulse cycle"}, last_cyc, e_cyc);
        check(last_acc == exp, {tag, " decision"}, int'(last_acc), int'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(dec_valid == 1'b0, "R1 dec_valid low in reset", int'(dec_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: zero local address after reset
        send_frame(48'h00_00_00_00_00_00, 6, 2, -1, -1, 1'b1, "R1 zero address");
        // R5: multicast with filtering off after reset
        send_frame(48'h01_00_00_00_00_00, 6, 0, -1, -1, 1'b1, "R5 multicast at reset");

        cfg_write(0, 32'h0000_0211);
        cfg_write(1, 32'h2233_4455);
        cfg_write(2, 32'h00F0_0001);
        cfg_write(3, 32'h0000_0001);

        // R2 R3 R4 R6: vector walk
        for (int v = 0; v <= 8; v++)
            send_frame(VECS[v].da, 6, int'(VECS[v].pay), -1, -1, VECS[v].exp,
                       $sformatf("R2/R3/R4/R6 vector %0d", v));

        // R8: idle cycles in the middle of the address
        send_frame(48'h02_11_22_33_44_55, 6, 1, -1, 3, 1'b1, "R8 gap in address");
        send_frame(48'h02_11_22_33_44_55, 6, 0, -1, 5, 1'b1, "R8 gap before last byte");
        // R8: start flag inside address and inside payload
        send_frame(48'h02_11_22_33_44_55, 6, 2, 3, -1, 1'b1, "R8 sof inside address");
        send_frame(48'hFF_FF_FF_FF_FF_FF, 6, 4, 8, -1, 1'b1, "R8 sof inside payload");

        // R7: short frames
        send_frame(48'h02_11_22_33_44_55, 1, 0, -1, -1, 1'b0, "R7 one byte frame");
        send_frame(48'hFF_FF_FF_FF_FF_FF, 3, 0, -1, -1, 1'b0, "R7 three byte frame");
        send_frame(48'h02_11_22_33_44_55, 5, 0, -1, -1, 1'b0, "R7 five byte frame");

        // R9: stray bytes with no frame open
        begin
            int base;
            base = npulse;
            for (int i = 0; i < 8; i++) begin
                in_valid = 1; in_sof = 0; in_eof = (i == 7); in_byte = 8'hFF;
                @(negedge clk);
            end
            in_valid = 0; in_eof = 0;
            repeat (3) @(negedge clk);
            check(npulse == base, "R9 stray bytes ignored", npulse - base, 0);
        end
        send_frame(48'h02_11_22_33_44_55, 6, 0, -1, -1, 1'b1, "R9 frame after strays");

        // R10: zero mask with filtering on
        cfg_write(2, 32'h0000_0000);
        send_frame(48'h03_11_22_33_44_55, 6, 1, -1, -1, 1'b1, "R10 zero mask");
        send_frame(48'h01_00_00_00_00_00, 6, 0, -1, -1, 1'b1, "R10 zero mask low bits clear");

        // R4: single-bit miss in the top octet of the low word
        cfg_write(2, 32'h8000_0000);
        send_frame(48'h01_00_7F_FF_FF_FF, 6, 0, -1, -1, 1'b0, "R4 top bit missing");
        send_frame(48'h01_00_80_00_00_00, 6, 0, -1, -1, 1'b1, "R4 top bit present");

        // R5: filtering off with a mask that would reject
        cfg_write(3, 32'h0000_0000);
        send_frame(48'h01_00_7F_FF_FF_FF, 6, 0, -1, -1, 1'b1, "R5 filter off");

        // R2: reprogram local address, old address now rejected
        cfg_write(0, 32'h0000_A0B1);
        cfg_write(1, 32'hC2D3_E4F4);
        send_frame(48'h02_11_22_33_44_55, 6, 0, -1, -1, 1'b0, "R2 old address");
        send_frame(48'hA0_B1_C2_D3_E4_F4, 6, 1, -1, -1, 1'b1, "R2 new address");
        send_frame(48'hA0_B1_C2_D3_E4_F5, 6, 0, -1, -1, 1'b0, "R2 last bit differs");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule